// File: doc/BRIEF.md
# Synchronous Serial Port Controller (Master/Slave)

This block is a full-duplex synchronous serial port that can act as the clock-driving master or as a clocked slave. Each frame carries one character of 1 to 8 bits. The character is shifted out on one data line while the reply is shifted in on the other. In master mode the block drives the serial clock from a programmable divider of the system clock, and it asserts an active-low select line for the whole frame. In slave mode it samples the external clock, data and select lines through synchronisers and responds only while it is selected.

Software reaches six 8-bit registers over a 16-bit host bus. From these registers it chooses the role, the clock polarity, the clock phase, the character length and the bit rate. It can also switch off the transmit driver while reception goes on. In master mode, writing a character to the transmit register starts a frame. Software can learn that a frame has finished in two ways: by polling a status flag, or through an interrupt line that it enables separately. An overrun flag records that a character arrived before the previous one was read.

Top module: `sync_serial_ctl`

## Requirements
- R1: The register addresses are 0 control, 1 length, 2 divider, 3 status, 4 transmit and 5 receive. A read returns its data one cycle after `bus_rd`, with bits 15:8 always zero. Bits 15:8 of a write have no effect on any register.
- R2: The length register bits 2:0 hold the character length minus one. A frame shifts exactly that many bits, and bit 7 of the transmit byte goes out first.
- R3: The received bits appear right-justified in the receive register, with the first received bit as the most significant of them, and all bits above the length read as zero.
- R4: Control bit 1 is the clock polarity, and it sets the idle level of the master clock. With control bit 2 (phase) at 0, data is sampled on the edge that leaves the idle level and changes on the edge that returns to it. With polarity 0, this means data changes on the falling edge and is sampled on the rising edge.
- R5: With phase 1, each bit is put on the line at the edge that leaves the idle level, which is half a clock ahead of the edge that returns to idle. That returning edge is where the bit is sampled.
- R6: In master mode each bit lasts max(D,3)+1 system clocks, where D is bits 6:0 of the divider register. This gives 125 distinct rates, and the fastest is the system clock divided by 4.
- R7: Control bit 3 enables transmit. While it is 0, neither `mosi_oe` nor `miso_oe` is asserted, and reception still completes with correct data.
- R8: Status bit 0 (done) is set when a frame completes and is cleared by a read of the receive register. `irq` is high exactly while done is set and control bit 4 (interrupt enable) is 1.
- R9: Status bit 1 (overrun) is set when a frame completes while done is still set. A read of the receive register clears it.
- R10: In slave mode (control bit 0 = 0), the block ignores `sclk_i` and keeps `miso_oe` low while `ste_n_i` is high. While `ste_n_i` is low and transmit is enabled, it drives `miso_o`.
- R11: In master mode (control bit 0 = 1), `sclk_oe` is 1 and `ste_n_o` is low exactly during a frame. In slave mode, `sclk_oe` and `mosi_oe` are 0 and `ste_n_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Frame-complete interrupt request |
| sclk_i | input | 1 | Serial clock input (slave) |
| sclk_o | output | 1 | Serial clock output (master) |
| sclk_oe | output | 1 | Serial clock drive enable |
| mosi_i | input | 1 | Master-out line, input side (slave) |
| mosi_o | output | 1 | Master-out line, output side |
| mosi_oe | output | 1 | Master-out drive enable |
| miso_i | input | 1 | Master-in line, input side (master) |
| miso_o | output | 1 | Master-in line, output side |
| miso_oe | output | 1 | Master-in drive enable |
| ste_n_i | input | 1 | Active-low select input (slave) |
| ste_n_o | output | 1 | Active-low select output (master) |

## Verification
The assertions assume the following about the inputs:
- `ste_n_i` is high during reset.
- Reads and writes do not overlap.
- In slave mode, `sclk_i` half-periods are much longer than the two-stage synchroniser.
- `mosi_i` changes only away from the clock edges on which the slave samples it.

The stimulus stays inside these limits:
- It holds the select line high through reset and between frames.
- It uses separate, non-overlapping bus cycles.
- It drives the slave clock with eight-system-clock half-periods and changes data only at the edge that does not sample.

The master sweep covers every polarity and phase pair at every length. It also covers every divider value from 0 to 127.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int REG_W = 8;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_LEN  = 3'd1,
    A_BAUD = 3'd2,
    A_STAT = 3'd3,
    A_TX   = 3'd4,
    A_RX   = 3'd5
  } reg_addr_e;

  // bit 4 irq_en, bit 3 tx_en, bit 2 cpha, bit 1 cpol, bit 0 master
  typedef struct packed {
    logic irq_en;
    logic tx_en;
    logic cpha;
    logic cpol;
    logic master;
  } ctrl_t;
endpackage

// File: rtl/ssc_baud.sv
module ssc_baud #(
  parameter int DIV_W   = 7,
  parameter int MIN_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             lead,
  output logic             trail
);
  localparam int CW = DIV_W + 1;

  logic [CW-1:0] period, half, cnt;

  always_comb begin
    if ({1'b0, div} < CW'(MIN_DIV - 1)) period = CW'(MIN_DIV);
    else                                period = {1'b0, div} + 1'b1;
    half = period >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst || !run)               cnt <= '0;
    else if (cnt == period - 1'b1) cnt <= '0;
    else                           cnt <= cnt + 1'b1;
  end

  assign lead  = run && (cnt == half - 1'b1);
  assign trail = run && (cnt == period - 1'b1);
endmodule

// File: rtl/ssc_sync.sv
module ssc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cpol,
  input  logic sclk_i,
  input  logic mosi_i,
  input  logic ste_n_i,
  output logic selected,
  output logic din,
  output logic lead,
  output logic trail
);
  logic [STAGES-1:0] clk_sh, dat_sh, sel_sh;
  logic              clk_prev;
  logic              sclk_s, edge_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sh   <= '0;
      dat_sh   <= '0;
      sel_sh   <= '1;
      clk_prev <= 1'b0;
    end else begin
      clk_sh   <= {clk_sh[STAGES-2:0], sclk_i};
      dat_sh   <= {dat_sh[STAGES-2:0], mosi_i};
      sel_sh   <= {sel_sh[STAGES-2:0], ste_n_i};
      clk_prev <= sclk_s;
    end
  end

  assign sclk_s    = clk_sh[STAGES-1];
  assign selected  = !sel_sh[STAGES-1];
  assign din       = dat_sh[STAGES-1];
  assign edge_seen = selected && (sclk_s != clk_prev);
  assign lead      = edge_seen && (clk_prev == cpol);
  assign trail     = edge_seen && (clk_prev != cpol);
endmodule

// File: rtl/ssc_shift.sv
module ssc_shift #(
  parameter int DW = 8,
  localparam int LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic [LW-1:0] len_m1,
  input  logic          cpha,
  input  logic          clear,
  input  logic          lead,
  input  logic          trail,
  input  logic          din,
  output logic          dout,
  output logic          done_pulse,
  output logic [DW-1:0] rx_data
);
  logic [DW-1:0] sh, sh_next, mask;
  logic [LW-1:0] bcnt;
  logic          smp;

  always_comb begin
    sh_next = {sh[DW-2:0], cpha ? din : smp};
    mask    = ~({DW{1'b1}} << ({1'b0, len_m1} + 1'b1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh         <= '0;
      bcnt       <= '0;
      smp        <= 1'b0;
      dout       <= 1'b0;
      done_pulse <= 1'b0;
      rx_data    <= '0;
    end else begin
      done_pulse <= 1'b0;
      if (load) begin
        sh   <= load_data;
        bcnt <= '0;
        dout <= load_data[DW-1];
      end else if (clear) begin
        bcnt <= '0;
      end else if (lead) begin
        if (!cpha) smp  <= din;
        else       dout <= sh[DW-1];
      end else if (trail) begin
        sh <= sh_next;
        if (!cpha) dout <= sh[DW-2];
        if (bcnt == len_m1) begin
          bcnt       <= '0;
          done_pulse <= 1'b1;
          rx_data    <= sh_next & mask;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sync_serial_ctl.sv
module sync_serial_ctl
  import ssc_pkg::*;
#(
  parameter int BUS_W       = 16,
  parameter int DW          = 8,
  parameter int DIV_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq,
  input  logic             sclk_i,
  output logic             sclk_o,
  output logic             sclk_oe,
  input  logic             mosi_i,
  output logic             mosi_o,
  output logic             mosi_oe,
  input  logic             miso_i,
  output logic             miso_o,
  output logic             miso_oe,
  input  logic             ste_n_i,
  output logic             ste_n_o
);
  localparam int LW = $clog2(DW);

  ctrl_t            ctrl_q;
  logic [LW-1:0]    len_q;
  logic [DIV_W-1:0] baud_q;
  logic             done_q, ovr_q, busy_q, sclk_q;
  logic [REG_W-1:0] rd_byte;
  logic             unused_bits;

  logic tx_wr, rx_rd, start, load;
  logic m_lead, m_trail, s_lead, s_trail, s_sel, s_din;
  logic ev_lead, ev_trail, ev_din, dout, done_pulse;
  logic [DW-1:0] rx_data;

  assign unused_bits = ^bus_wdata;
  assign tx_wr = bus_wr && (bus_addr == A_TX);
  assign rx_rd = bus_rd && (bus_addr == A_RX);
  assign start = tx_wr && ctrl_q.master && !busy_q;
  assign load  = start || (tx_wr && !ctrl_q.master);

  ssc_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .run(busy_q && ctrl_q.master), .div(baud_q),
    .lead(m_lead), .trail(m_trail)
  );

  ssc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cpol(ctrl_q.cpol), .sclk_i(sclk_i),
    .mosi_i(mosi_i), .ste_n_i(ste_n_i), .selected(s_sel),
    .din(s_din), .lead(s_lead), .trail(s_trail)
  );

  assign ev_lead  = ctrl_q.master ? m_lead  : s_lead;
  assign ev_trail = ctrl_q.master ? m_trail : s_trail;
  assign ev_din   = ctrl_q.master ? miso_i  : s_din;

  ssc_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .load(load), .load_data(bus_wdata[DW-1:0]),
    .len_m1(len_q), .cpha(ctrl_q.cpha), .clear(!ctrl_q.master && !s_sel),
    .lead(ev_lead), .trail(ev_trail), .din(ev_din), .dout(dout),
    .done_pulse(done_pulse), .rx_data(rx_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      len_q  <= '0;
      baud_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL:  ctrl_q <= ctrl_t'(bus_wdata[$bits(ctrl_t)-1:0]);
        A_LEN:   len_q  <= bus_wdata[LW-1:0];
        A_BAUD:  baud_q <= bus_wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (!ctrl_q.master)  busy_q <= 1'b0;
      else if (start)      busy_q <= 1'b1;
      else if (done_pulse) busy_q <= 1'b0;

      if (!ctrl_q.master || !busy_q) sclk_q <= ctrl_q.cpol;
      else if (m_lead)               sclk_q <= ~ctrl_q.cpol;
      else if (m_trail)              sclk_q <= ctrl_q.cpol;

      if (done_pulse)  done_q <= 1'b1;
      else if (rx_rd)  done_q <= 1'b0;

      if (done_pulse && done_q && !rx_rd) ovr_q <= 1'b1;
      else if (rx_rd)                     ovr_q <= 1'b0;
    end
  end

  always_comb begin
    rd_byte = '0;
    case (bus_addr)
      A_CTRL:  rd_byte[$bits(ctrl_t)-1:0] = ctrl_q;
      A_LEN:   rd_byte[LW-1:0]            = len_q;
      A_BAUD:  rd_byte[DIV_W-1:0]         = baud_q;
      A_STAT:  rd_byte[1:0]               = {ovr_q, done_q};
      A_RX:    rd_byte[DW-1:0]            = rx_data;
      default: rd_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= {{(BUS_W-REG_W){1'b0}}, rd_byte};
  end

  assign irq     = done_q && ctrl_q.irq_en;
  assign sclk_o  = sclk_q;
  assign sclk_oe = ctrl_q.master;
  assign ste_n_o = !(ctrl_q.master && busy_q);
  assign mosi_o  = dout;
  assign mosi_oe = ctrl_q.master && ctrl_q.tx_en;
  assign miso_o  = dout;
  assign miso_oe = !ctrl_q.master && ctrl_q.tx_en && s_sel;
endmodule

// File: rtl/ssc_chk.sv
module ssc_chk #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [BUS_W-1:0] bus_rdata,
  input logic             ste_n_o,
  input logic             sclk_o,
  input logic             cpol,
  input logic             tx_en,
  input logic             mosi_oe,
  input logic             miso_oe,
  input logic             done,
  input logic             ovr,
  input logic             master,
  input logic             ste_n_i
);
  AST_HI_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[BUS_W-1:8] == '0); // R1

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (ste_n_o && $past(ste_n_o) && $stable(cpol)) |-> (sclk_o == cpol)); // R4

  AST_DRIVE_NEEDS_TX: assert property (@(posedge clk) disable iff (rst)
    !tx_en |-> (!mosi_oe && !miso_oe)); // R7

  AST_OVR_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr) |-> $past(done)); // R9

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!master && ste_n_i && $past(ste_n_i) && $past(ste_n_i, 2)) |-> !miso_oe); // R10
endmodule

bind sync_serial_ctl ssc_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .bus_rdata(bus_rdata), .ste_n_o(ste_n_o),
  .sclk_o(sclk_o), .cpol(ctrl_q.cpol), .tx_en(ctrl_q.tx_en),
  .mosi_oe(mosi_oe), .miso_oe(miso_oe), .done(done_q), .ovr(ovr_q),
  .master(ctrl_q.master), .ste_n_i(ste_n_i)
);

// File: tb/sync_serial_ctl_test.sv
module sync_serial_ctl_test;
  localparam logic [2:0] RA_CTRL = 3'd0, RA_LEN = 3'd1, RA_BAUD = 3'd2,
                         RA_STAT = 3'd3, RA_TX = 3'd4, RA_RX = 3'd5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq, sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe, ste_n_o;
  logic sclk_i = 1'b0, mosi_i = 1'b0, ste_n_i = 1'b1, m_miso = 1'b0;

  sync_serial_ctl uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(m_miso), .miso_o(miso_o), .miso_oe(miso_oe),
    .ste_n_i(ste_n_i), .ste_n_o(ste_n_o)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // external device model for master mode, evaluated away from the active edge
  bit        mdl_cpol = 0, mdl_cpha = 0;
  logic [7:0] mdl_resp = '0, mdl_got = '0;
  int        mdl_k = 0, last_lead = -1, lead_period = -1;
  logic      prev_sclk = 1'b0, prev_ste = 1'b1;

  always @(negedge clk) begin
    if (!ste_n_o && prev_ste) begin
      mdl_k = 0; mdl_got = '0; last_lead = -1;
      if (!mdl_cpha) m_miso = mdl_resp[7];
    end else if (!ste_n_o) begin
      if (prev_sclk == mdl_cpol && sclk_o != mdl_cpol) begin
        if (last_lead >= 0) lead_period = cyc - last_lead;
        last_lead = cyc;
        if (!mdl_cpha) mdl_got = {mdl_got[6:0], mosi_o};
        else if (mdl_k < 8) m_miso = mdl_resp[7-mdl_k];
      end else if (prev_sclk != mdl_cpol && sclk_o == mdl_cpol) begin
        if (mdl_cpha) mdl_got = {mdl_got[6:0], mosi_o};
        mdl_k++;
        if (!mdl_cpha && mdl_k < 8) m_miso = mdl_resp[7-mdl_k];
      end
    end
    prev_sclk = sclk_o;
    prev_ste  = ste_n_o;
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_done();
    logic [15:0] s;
    int guard;
    guard = 0;
    s = '0;
    while (!s[0] && guard < 4000) begin rd(RA_STAT, s); guard++; end
    chk(s[0] == 1'b1, "R8 done flag", s, 1);
  endtask

  task automatic mxfer(input logic [7:0] tx, input logic [7:0] resp, output logic [15:0] rx);
    mdl_resp = resp;
    lead_period = -1;
    wr(RA_TX, {8'h00, tx});
    wait_done();
    rd(RA_RX, rx);
  endtask

  task automatic sxfer(input int mode, input int len, input logic [7:0] mo, input logic [7:0] so);
    logic [7:0]  got;
    logic [15:0] v;
    bit          pol, pha;
    pol = mode[0]; pha = mode[1];
    got = '0;
    @(negedge clk); sclk_i = pol; ste_n_i = 1'b1;
    wr(RA_TX, {8'h00, so});
    repeat (8) @(negedge clk);
    ste_n_i = 1'b0;
    repeat (8) @(negedge clk);
    chk(miso_oe == 1'b1, "R10 slave drives when selected", miso_oe, 1);
    for (int i = 0; i < len; i++) begin
      if (!pha) begin
        mosi_i = mo[7-i];
        repeat (8) @(negedge clk);
        got = {got[6:0], miso_o}; sclk_i = ~pol;
        repeat (8) @(negedge clk);
        sclk_i = pol;
      end else begin
        repeat (8) @(negedge clk);
        sclk_i = ~pol; mosi_i = mo[7-i];
        repeat (8) @(negedge clk);
        got = {got[6:0], miso_o}; sclk_i = pol;
      end
    end
    repeat (8) @(negedge clk);
    ste_n_i = 1'b1;
    repeat (6) @(negedge clk);
    rd(RA_STAT, v);
    chk(v[0] == 1'b1, "R8 slave done", v, 1);
    rd(RA_RX, v);
    chk(v == 16'(mo >> (8 - len)), "R3 slave rx", v, mo >> (8 - len));
    chk(got == (so >> (8 - len)), "R2 slave tx bits", got, so >> (8 - len));
  endtask

  initial begin
    #(20 * 190000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  tx, rp;
    int          ex;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    rd(RA_CTRL, v); chk(v == 0, "R1 ctrl reset", v, 0);
    rd(RA_STAT, v); chk(v == 0, "R8 status reset", v, 0);
    chk(ste_n_o == 1'b1, "R11 select idle", ste_n_o, 1);
    chk(irq == 1'b0, "R8 irq reset", irq, 0);
    chk(mosi_oe == 1'b0, "R7 no drive at reset", mosi_oe, 0);

    // R1: upper byte of writes ignored, reads zero-extended
    wr(RA_CTRL, 16'hA51B); rd(RA_CTRL, v); chk(v == 16'h001B, "R1 ctrl upper ignored", v, 16'h1B);
    wr(RA_BAUD, 16'hFF7F); rd(RA_BAUD, v); chk(v == 16'h007F, "R1 baud upper ignored", v, 16'h7F);
    wr(RA_LEN, 16'h3C05);  rd(RA_LEN, v);  chk(v == 16'h0005, "R1 len upper ignored", v, 5);

    // master sweep over modes and lengths (R2 R3 R4 R5)
    for (int mode = 0; mode < 4; mode++) begin
      for (int len = 1; len <= 8; len++) begin
        mdl_cpol = mode[0]; mdl_cpha = mode[1];
        wr(RA_CTRL, 16'(8 | (mode[1] << 2) | (mode[0] << 1) | 1));
        wr(RA_LEN, 16'(len - 1));
        wr(RA_BAUD, 16'(3 + len % 3));
        chk(sclk_oe == 1'b1, "R11 master drives clock", sclk_oe, 1);
        chk(sclk_o == mode[0], "R4 idle polarity", sclk_o, mode[0]);
        tx = 8'h5A ^ 8'(len * 37 + mode * 11);
        rp = 8'hC3 + 8'(len * 29 + mode * 7);
        mxfer(tx, rp, v);
        chk(v == 16'(rp >> (8 - len)), mode[1] ? "R5 master rx" : "R4 master rx", v, rp >> (8 - len));
        chk(mdl_got == (tx >> (8 - len)), "R2 master tx bits", mdl_got, tx >> (8 - len));
        chk(ste_n_o == 1'b1, "R11 select released", ste_n_o, 1);
      end
    end

    // R6 divider sweep
    mdl_cpol = 0; mdl_cpha = 0;
    wr(RA_CTRL, 16'h0009);
    wr(RA_LEN, 16'd1);
    for (int b = 0; b < 128; b++) begin
      wr(RA_BAUD, 16'(b));
      mxfer(8'hA0, 8'h40, v);
      ex = (b < 3) ? 4 : b + 1;
      chk(lead_period == ex, "R6 bit period", lead_period, ex);
    end

    // R7 transmit disabled, receive works
    wr(RA_CTRL, 16'h0001);
    wr(RA_LEN, 16'd7);
    wr(RA_BAUD, 16'd4);
    chk(mosi_oe == 1'b0, "R7 mosi not driven", mosi_oe, 0);
    mxfer(8'hFF, 8'h96, v);
    chk(v == 16'h0096, "R7 rx while tx off", v, 16'h96);

    // R8 interrupt
    wr(RA_CTRL, 16'h0019);
    mdl_resp = 8'h3C;
    wr(RA_TX, 16'h0011);
    wait_done();
    @(negedge clk);
    chk(irq == 1'b1, "R8 irq on done", irq, 1);
    rd(RA_RX, v);
    chk(v == 16'h003C, "R3 rx value", v, 16'h3C);
    @(negedge clk);
    chk(irq == 1'b0, "R8 irq cleared", irq, 0);
    rd(RA_STAT, v); chk(v == 0, "R8 done cleared", v, 0);

    // R9 overrun
    mdl_resp = 8'h81;
    wr(RA_TX, 16'h0022);
    wait_done();
    mdl_resp = 8'h7E;
    wr(RA_TX, 16'h0033);
    repeat (60) @(negedge clk);
    rd(RA_STAT, v); chk(v == 16'h0003, "R9 overrun set", v, 3);
    rd(RA_RX, v);   chk(v == 16'h007E, "R9 latest char kept", v, 16'h7E);
    rd(RA_STAT, v); chk(v == 0, "R9 overrun cleared", v, 0);

    // R8 interrupt disabled
    wr(RA_CTRL, 16'h0009);
    mdl_resp = 8'h12;
    wr(RA_TX, 16'h0044);
    wait_done();
    @(negedge clk);
    chk(irq == 1'b0, "R8 irq masked", irq, 0);
    rd(RA_RX, v);

    // slave mode
    wr(RA_CTRL, 16'h0008);
    @(negedge clk);
    chk(sclk_oe == 1'b0, "R11 slave clock input", sclk_oe, 0);
    chk(mosi_oe == 1'b0, "R11 slave mosi input", mosi_oe, 0);
    chk(ste_n_o == 1'b1, "R11 slave select high", ste_n_o, 1);
    wr(RA_TX, 16'h00A5);
    for (int i = 0; i < 20; i++) begin
      repeat (4) @(negedge clk);
      sclk_i = ~sclk_i; mosi_i = i[1];
      chk(miso_oe == 1'b0, "R10 deselected quiet", miso_oe, 0);
    end
    sclk_i = 1'b0;
    repeat (6) @(negedge clk);
    rd(RA_STAT, v); chk(v == 0, "R10 clock ignored", v, 0);

    for (int mode = 0; mode < 4; mode++) begin
      for (int k = 0; k < 3; k++) begin
        int len;
        len = (k == 0) ? 8 : (k == 1) ? 5 : 3;
        wr(RA_CTRL, 16'(8 | (mode[1] << 2) | (mode[0] << 1)));
        wr(RA_LEN, 16'(len - 1));
        sxfer(mode, len, 8'h69 ^ 8'(mode * 13 + len), 8'hB4 + 8'(mode * 17 + len * 3));
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule